// File: doc/BRIEF.md
# Dual Mode-Selectable Timer/Counter

This block holds two timer/counter channels, channel 0 and channel 1, each built from a low count byte and a high count byte. One 8-bit mode register sets how each channel counts. Each channel can run as a 13-bit counter, a 16-bit counter, or an 8-bit counter that reloads itself. A fourth setting splits channel 0 into two separate 8-bit counters. Each channel picks its count source. It can count ticks of an internal clock, which is either every system clock or a prescale strobe supplied from outside. It can also count falling edges on its own external pin. Counting can also be gated by a per-channel enable input whose active level is programmable.

Software reaches the mode register and the four count bytes through a simple synchronous register port. Each channel drives a sticky overflow flag, and software clears it through a per-channel clear input. The run bits, clock selects and gate polarities arrive as plain inputs from elsewhere in the chip.

Top module: `dual_tmr_cnt`

## Requirements
- R1: A synchronous reset clears the mode register, all four count bytes, both overflow flags and the read data register to 0.
- R2: Register addresses are 0 = mode, 1 = channel 0 low byte, 2 = channel 0 high byte, 3 = channel 1 low byte, 4 = channel 1 high byte, and addresses 5 to 7 read as 0. Mode bits from bit 7 down are: ch1 gate, ch1 source, ch1 mode[1:0], ch0 gate, ch0 source, ch0 mode[1:0]. A write lands at the clock edge. `reg_rdata` shows the value the addressed register held before the edge at which the address was presented, and it is valid after that edge.
- R3: Mode 00 (13-bit): each increment adds 1 to bits 4:0 of the low byte, and bits 7:5 of the low byte stay unchanged. When bits 4:0 wrap from 31 to 0, the high byte increments. When the high byte is also 0xFF, the whole count wraps to 0 and the channel's flag sets.
- R4: Mode 01 (16-bit): {high, low} increments as one 16-bit value. Wrapping from 0xFFFF to 0 sets the channel's flag.
- R5: Mode 10 (auto-reload): the low byte increments. On an increment at 0xFF, the low byte loads the high byte's value and the flag sets. Counting never changes the high byte.
- R6: Mode 11 on channel 0 (split): the low byte is a free 8-bit counter under channel 0's run, gate and source, and it sets flag 0 when it wraps from 0xFF. The high byte counts internal ticks of channel 1 (run 1, clock select 1) and sets flag 1 when it wraps. In this mode channel 1 holds its count bytes.
- R7: Mode 11 on channel 1 makes channel 1 inactive: its bytes change only through writes, and flag 1 is not set by channel 1.
- R8: A channel counts only while its run input is 1. With its gate bit clear, the gate input is ignored. With its gate bit set, it counts only while the gate input equals the gate polarity input (1 = active high).
- R9: With the source bit 0, an internal tick is every clock when clock select is 1, or a cycle with `prescale_tick` high when clock select is 0. With the source bit 1, each high-to-low change of the count pin gives one increment. The pin passes through two synchronizer flops, so a low level first present at clock edge k is counted at edge k+2. There is at most one increment per clock.
- R10: A write to a count byte in the same cycle as an increment wins. In modes 00, 01 and 10, a write to either byte of a channel cancels that channel's increment and overflow for the cycle. In split mode, a write cancels only its own byte's increment.
- R11: A flag stays set until its clear input is 1 for a cycle. If a set and a clear occur in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| prescale_tick | input | 1 | One-cycle strobe from an external prescaler |
| run | input | 2 | Per-channel run enable |
| clksel | input | 2 | Per-channel internal clock select (1 = every clock, 0 = prescale strobe) |
| gate_in | input | 2 | Per-channel external gate level |
| gate_pol | input | 2 | Per-channel gate active level (1 = high) |
| cnt_pin | input | 2 | Per-channel external count pin, asynchronous |
| ovf_clr | input | 2 | Per-channel flag clear |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| ovf | output | 2 | Sticky overflow flags |

## Verification
A wrong count state shows in one of two ways. If a byte is mis-stepped, it appears on `reg_rdata` the next time that address is read, and the bench sweeps all addresses every eight idle cycles. If a carry is lost or spurious, `ovf` goes wrong one clock after the faulty wrap. Because every later count builds on the corrupted value, one bad increment keeps the bytes apart from the reference model from then on. An error in gating, source selection or the synchronizer delay therefore turns into a count mismatch within a few cycles of the first affected edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NCH    = 2;
  localparam int ADDR_W = 3;

  localparam int A_MODE = 0;
  localparam int A_T0L  = 1;
  localparam int A_T0H  = 2;
  localparam int A_T1L  = 3;
  localparam int A_T1H  = 4;

  typedef enum logic [1:0] {
    TM_13     = 2'b00,
    TM_16     = 2'b01,
    TM_RELOAD = 2'b10,
    TM_SPLIT  = 2'b11
  } tmr_mode_e;
endpackage

// File: rtl/tmr_pin_edge.sv
module tmr_pin_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= sync_q[STAGES-1];
    end
  end

  // a 1-to-0 change between consecutive synchronized samples
  assign fall = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int W        = 8,
  parameter int PRE      = 5,
  parameter bit SPLIT_OK = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  tmr_mode_e    mode,
  input  logic         inc,
  input  logic         inc_hi,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] lo_q,
  output logic [W-1:0] hi_q,
  output logic         evt_lo,
  output logic         evt_hi
);
  logic [W-1:0] lo_n, hi_n;

  always_comb begin
    lo_n   = lo_q;
    hi_n   = hi_q;
    evt_lo = 1'b0;
    evt_hi = 1'b0;
    case (mode)
      TM_13: if (inc) begin
        lo_n[PRE-1:0] = lo_q[PRE-1:0] + 1'b1;
        if (&lo_q[PRE-1:0]) begin
          hi_n = hi_q + 1'b1;
          if (&hi_q) evt_lo = 1'b1;
        end
      end
      TM_16: if (inc) begin
        {hi_n, lo_n} = {hi_q, lo_q} + 1'b1;
        if (&{hi_q, lo_q}) evt_lo = 1'b1;
      end
      TM_RELOAD: if (inc) begin
        if (&lo_q) begin
          lo_n   = hi_q;
          evt_lo = 1'b1;
        end else begin
          lo_n = lo_q + 1'b1;
        end
      end
      default: if (SPLIT_OK) begin
        if (inc) begin
          lo_n   = lo_q + 1'b1;
          evt_lo = &lo_q;
        end
        if (inc_hi) begin
          hi_n   = hi_q + 1'b1;
          evt_hi = &hi_q;
        end
      end
    endcase

    // software writes override counting
    if (mode == TM_SPLIT && SPLIT_OK) begin
      if (wr_lo) begin
        lo_n   = wdata;
        evt_lo = 1'b0;
      end
      if (wr_hi) begin
        hi_n   = wdata;
        evt_hi = 1'b0;
      end
    end else if (wr_lo || wr_hi) begin
      lo_n   = wr_lo ? wdata : lo_q;
      hi_n   = wr_hi ? wdata : hi_q;
      evt_lo = 1'b0;
      evt_hi = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end
endmodule

// File: rtl/dual_tmr_cnt.sv
module dual_tmr_cnt
  import tmr_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int PRE_BITS    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prescale_tick,
  input  logic [NCH-1:0]    run,
  input  logic [NCH-1:0]    clksel,
  input  logic [NCH-1:0]    gate_in,
  input  logic [NCH-1:0]    gate_pol,
  input  logic [NCH-1:0]    cnt_pin,
  input  logic [NCH-1:0]    ovf_clr,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic [NCH-1:0]    ovf
);
  localparam int FLD_W  = 4;
  localparam int MODE_W = FLD_W * NCH;

  logic [MODE_W-1:0] mode_q;
  logic [NCH-1:0]    fall, int_tick, gate_ok, tick;
  logic [NCH-1:0]    inc, inc_hi, wr_lo, wr_hi, evt_lo, evt_hi, ovf_set;
  logic [BYTE_W-1:0] lo_w [NCH];
  logic [BYTE_W-1:0] hi_w [NCH];
  logic              t0_split;

  assign t0_split = (mode_q[1:0] == TM_SPLIT);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= '0;
    else if (reg_wr_en && reg_addr == ADDR_W'(A_MODE)) mode_q <= reg_wdata[MODE_W-1:0];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [FLD_W-1:0] fld;
    assign fld = mode_q[FLD_W*c +: FLD_W];

    tmr_pin_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk  (clk),
      .rst  (rst),
      .pin  (cnt_pin[c]),
      .fall (fall[c])
    );

    assign int_tick[c] = clksel[c] | prescale_tick;
    assign gate_ok[c]  = ~fld[3] | (gate_in[c] ~^ gate_pol[c]);
    assign tick[c]     = run[c] & gate_ok[c] & (fld[2] ? fall[c] : int_tick[c]);
    assign wr_lo[c]    = reg_wr_en && (reg_addr == ADDR_W'(A_T0L + 2*c));
    assign wr_hi[c]    = reg_wr_en && (reg_addr == ADDR_W'(A_T0H + 2*c));

    tmr_channel #(.W(BYTE_W), .PRE(PRE_BITS), .SPLIT_OK(c == 0)) u_chan (
      .clk    (clk),
      .rst    (rst),
      .mode   (tmr_mode_e'(fld[1:0])),
      .inc    (inc[c]),
      .inc_hi (inc_hi[c]),
      .wr_lo  (wr_lo[c]),
      .wr_hi  (wr_hi[c]),
      .wdata  (reg_wdata),
      .lo_q   (lo_w[c]),
      .hi_q   (hi_w[c]),
      .evt_lo (evt_lo[c]),
      .evt_hi (evt_hi[c])
    );
  end

  // channel 0 high byte borrows channel 1 controls in split mode; channel 1 then holds
  assign inc[0]     = tick[0];
  assign inc[1]     = tick[1] & ~t0_split;
  assign inc_hi[0]  = run[1] & int_tick[1];
  assign inc_hi[1]  = 1'b0;
  assign ovf_set[0] = evt_lo[0];
  assign ovf_set[1] = t0_split ? evt_hi[0] : (evt_lo[1] | evt_hi[1]);

  always_ff @(posedge clk) begin
    if (rst) ovf <= '0;
    else     ovf <= ovf_set | (ovf & ~ovf_clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        ADDR_W'(A_MODE): reg_rdata <= BYTE_W'(mode_q);
        ADDR_W'(A_T0L):  reg_rdata <= lo_w[0];
        ADDR_W'(A_T0H):  reg_rdata <= hi_w[0];
        ADDR_W'(A_T1L):  reg_rdata <= lo_w[1];
        ADDR_W'(A_T1H):  reg_rdata <= hi_w[1];
        default:         reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker (
  input logic       clk,
  input logic       rst,
  input logic [7:0] mode,
  input logic [1:0] run,
  input logic [1:0] ovf,
  input logic [1:0] ovf_clr,
  input logic       wr_en,
  input logic [2:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] lo0,
  input logic [7:0] hi0,
  input logic [7:0] lo1,
  input logic [7:0] hi1
);
  logic wr_t0, wr_t1;
  assign wr_t0 = wr_en && (addr == 3'd1 || addr == 3'd2);
  assign wr_t1 = wr_en && (addr == 3'd3 || addr == 3'd4);

  a_r2_mode_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd0) |=> (mode == $past(wdata)));

  a_r11_flag0_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf[0] && !ovf_clr[0]) |=> ovf[0]);

  a_r11_flag1_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf[1] && !ovf_clr[1]) |=> ovf[1]);

  a_r5_reload_hi_fixed: assert property (@(posedge clk) disable iff (rst)
    (mode[1:0] == 2'b10 && !(wr_en && addr == 3'd2)) |=> $stable(hi0));

  a_r6_split_t1_hold: assert property (@(posedge clk) disable iff (rst)
    (mode[1:0] == 2'b11 && !wr_t1) |=> ($stable(lo1) && $stable(hi1)));

  a_r7_t1_idle: assert property (@(posedge clk) disable iff (rst)
    (mode[5:4] == 2'b11 && !wr_t1) |=> ($stable(lo1) && $stable(hi1)));

  a_r8_stopped_t0: assert property (@(posedge clk) disable iff (rst)
    (!run[0] && mode[1:0] != 2'b11 && !wr_t0) |=> ($stable(lo0) && $stable(hi0)));
endmodule

bind dual_tmr_cnt tmr_checker u_tmr_checker (
  .clk     (clk),
  .rst     (rst),
  .mode    (mode_q),
  .run     (run),
  .ovf     (ovf),
  .ovf_clr (ovf_clr),
  .wr_en   (reg_wr_en),
  .addr    (reg_addr),
  .wdata   (reg_wdata),
  .lo0     (lo_w[0]),
  .hi0     (hi_w[0]),
  .lo1     (lo_w[1]),
  .hi1     (hi_w[1])
);

// File: tb/dual_tmr_cnt_bench.sv
`timescale 1ns/1ps
module dual_tmr_cnt_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       prescale_tick = 1'b0;
  logic [1:0] run = 2'b00, clksel = 2'b00, gate_in = 2'b00, gate_pol = 2'b00;
  logic [1:0] cnt_pin = 2'b11, ovf_clr = 2'b00;
  logic       reg_wr_en = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [1:0] ovf;

  always #10 clk = ~clk;

  dual_tmr_cnt u_dual_tmr_cnt (
    .clk(clk), .rst(rst), .prescale_tick(prescale_tick), .run(run), .clksel(clksel),
    .gate_in(gate_in), .gate_pol(gate_pol), .cnt_pin(cnt_pin), .ovf_clr(ovf_clr),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ovf(ovf)
  );

  // reference model state
  int    m_mode, m_rd;
  int    m_lo [2];
  int    m_hi [2];
  bit    m_ovf [2];
  bit    s1 [2];
  bit    s2 [2];
  bit    pv [2];
  int    nchk = 0, nfail = 0;
  string phase = "R1 reset";
  bit    done = 1'b0;
  logic [31:0] rs = 32'h1234_5678;
  int    rot = 0;

  function automatic int rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return int'(rs & 32'h7fff_ffff);
  endfunction

  function automatic bit wr(int a);
    return reg_wr_en && (int'(reg_addr) == a);
  endfunction

  task automatic adv(input int c, input int md, input bit inc, input bit wl, input bit wh, output bit ov);
    int v;
    ov = 1'b0;
    if (wl || wh) begin                     // R10: writes win
      if (wl) m_lo[c] = int'(reg_wdata);
      if (wh) m_hi[c] = int'(reg_wdata);
    end else if (inc) begin
      case (md)
        0: begin                            // R3
          if (m_lo[c] % 32 == 31) begin
            m_lo[c] = m_lo[c] - 31;
            if (m_hi[c] == 255) begin m_hi[c] = 0; ov = 1'b1; end
            else m_hi[c] = m_hi[c] + 1;
          end else m_lo[c] = m_lo[c] + 1;
        end
        1: begin                            // R4
          v = m_hi[c] * 256 + m_lo[c] + 1;
          if (v == 65536) begin v = 0; ov = 1'b1; end
          m_hi[c] = v / 256;
          m_lo[c] = v % 256;
        end
        default: begin                      // R5
          if (m_lo[c] == 255) begin m_lo[c] = m_hi[c]; ov = 1'b1; end
          else m_lo[c] = m_lo[c] + 1;
        end
      endcase
    end
  endtask

  always @(posedge clk) begin : model
    bit fall [2];
    bit itk [2];
    bit tk [2];
    bit set [2];
    bit ov;
    bit split, g, src;
    int md;
    if (rst) begin
      m_mode = 0; m_rd = 0;
      for (int c = 0; c < 2; c++) begin
        m_lo[c] = 0; m_hi[c] = 0; m_ovf[c] = 1'b0;
        s1[c] = 1'b0; s2[c] = 1'b0; pv[c] = 1'b0;
      end
    end else begin
      case (int'(reg_addr))
        0: m_rd = m_mode;
        1: m_rd = m_lo[0];
        2: m_rd = m_hi[0];
        3: m_rd = m_lo[1];
        4: m_rd = m_hi[1];
        default: m_rd = 0;
      endcase
      for (int c = 0; c < 2; c++) begin
        fall[c] = pv[c] && !s2[c];          // R9 two-stage sync then edge
        pv[c] = s2[c]; s2[c] = s1[c]; s1[c] = cnt_pin[c];
        g   = ((m_mode >> (4*c+3)) & 1) == 1;
        src = ((m_mode >> (4*c+2)) & 1) == 1;
        itk[c] = clksel[c] || prescale_tick;
        tk[c]  = run[c] && (!g || gate_in[c] == gate_pol[c]) && (src ? fall[c] : itk[c]);
        set[c] = 1'b0;
      end
      split = (m_mode & 3) == 3;
      md = m_mode & 3;
      if (md == 3) begin                    // R6
        if (wr(1)) m_lo[0] = int'(reg_wdata);
        else if (tk[0]) begin
          if (m_lo[0] == 255) begin m_lo[0] = 0; set[0] = 1'b1; end
          else m_lo[0] = m_lo[0] + 1;
        end
        if (wr(2)) m_hi[0] = int'(reg_wdata);
        else if (run[1] && itk[1]) begin
          if (m_hi[0] == 255) begin m_hi[0] = 0; set[1] = 1'b1; end
          else m_hi[0] = m_hi[0] + 1;
        end
      end else begin
        adv(0, md, tk[0], wr(1), wr(2), ov);
        set[0] = ov;
      end
      md = (m_mode >> 4) & 3;
      if (md == 3) begin                    // R7
        if (wr(3)) m_lo[1] = int'(reg_wdata);
        if (wr(4)) m_hi[1] = int'(reg_wdata);
      end else begin
        adv(1, md, tk[1] && !split, wr(3), wr(4), ov);
        set[1] = set[1] | ov;
      end
      for (int c = 0; c < 2; c++)
        m_ovf[c] = set[c] || (m_ovf[c] && !ovf_clr[c]);   // R11
      if (wr(0)) m_mode = int'(reg_wdata);
    end
  end

  task automatic chk();
    nchk++;
    if (ovf !== {m_ovf[1], m_ovf[0]} || reg_rdata !== 8'(m_rd)) begin
      nfail++;
      $display("FAIL %s: actual ovf=%b rdata=%h expected ovf=%b rdata=%h",
               phase, ovf, reg_rdata, {m_ovf[1], m_ovf[0]}, 8'(m_rd));
    end
  endtask

  task automatic set_mode(input logic [7:0] v);
    @(negedge clk);
    chk();
    ovf_clr   = 2'b00;
    reg_wr_en = 1'b1;
    reg_addr  = 3'd0;
    reg_wdata = v;
  endtask

  task automatic run_phase(input string nm, input int n, input int wr_mod, input int clr_mod);
    phase = nm;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk();
      prescale_tick = (rnd() % 3) == 0;
      for (int c = 0; c < 2; c++) begin
        if (rnd() % 5 == 0) gate_in[c] = ~gate_in[c];
        if (rnd() % 3 == 0) cnt_pin[c] = ~cnt_pin[c];
        ovf_clr[c] = (rnd() % clr_mod) == 0;
      end
      if (rnd() % wr_mod == 0) begin
        reg_wr_en = 1'b1;
        reg_addr  = 3'(1 + rnd() % 4);
        reg_wdata = 8'(rnd() % 2 == 0 ? (8'hF0 | rnd() % 16) : rnd() % 256);
      end else begin
        reg_wr_en = 1'b0;
        reg_addr  = 3'(rot);
        rot = (rot + 1) % 8;
      end
    end
  endtask

  initial begin
    repeat (3) begin @(negedge clk); chk(); end   // R1 reset state
    rst = 1'b0;
    run = 2'b11; clksel = 2'b11;
    set_mode(8'h5A);
    run_phase("R2 register map and readback", 60, 6, 50);
    set_mode(8'h01);
    run_phase("R4 16-bit count", 300, 16, 50);
    clksel = 2'b00;
    set_mode(8'h00);
    run_phase("R3 13-bit count on prescale strobe (R9 internal)", 600, 16, 50);
    clksel = 2'b11;
    set_mode(8'h22);
    run_phase("R5 auto-reload both channels", 600, 16, 50);
    set_mode(8'h55);
    run_phase("R9 external pin falling edges", 500, 32, 50);
    set_mode(8'hAA); gate_pol = 2'b01;
    run_phase("R8 gating with mixed polarity", 400, 16, 50);
    gate_pol = 2'b10;
    run_phase("R8 gating with swapped polarity", 400, 16, 50);
    set_mode(8'h22);
    run_phase("R8 gate bit clear ignores gate input", 200, 16, 50);
    set_mode(8'h13);
    run_phase("R6 split mode", 800, 16, 40);
    run = 2'b01;
    run_phase("R6 split mode with high byte stopped", 200, 16, 40);
    run = 2'b11; clksel = 2'b10;
    run_phase("R6 split mode, high byte on channel 1 clock", 200, 16, 40);
    clksel = 2'b11;
    set_mode(8'h31);
    run_phase("R7 channel 1 inactive", 300, 16, 50);
    set_mode(8'h22);
    run_phase("R10 write priority over increment", 300, 2, 50);
    run_phase("R11 sticky flags and clear", 400, 8, 3);
    run = 2'b00;
    set_mode(8'h11);
    run_phase("R8 run clear holds counts", 150, 16, 50);
    rst = 1'b1;
    phase = "R1 reset after activity";
    repeat (3) begin @(negedge clk); chk(); end
    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog in %s: actual=timeout expected=completion", phase);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule